// File: doc/BRIEF.md
# Processor Status Doubleword Control Unit

This unit keeps the 64-bit status doubleword that sets how a processor runs. It stores the privilege bit, the four condition codes, the addressing and trap-enable mode bits, the program counter field, the map controls and the current process index. Bits are numbered from 0 (most significant) to 63, and every field position below uses that numbering. The unit also keeps a separate interrupt-blocking flip-flop.

The unit takes three kinds of update. The first is a condition-code update from the arithmetic unit. The second is a load of a whole new doubleword, as happens on an interrupt, a trap or a load-status instruction; the load clears the reserved bits and applies a 2-bit blocking command. The third is a check of each decoded instruction against the privilege bit. An instruction marked privileged that arrives while the unit is unprivileged is held back, and a violation trap is requested. All outputs are registered, so each update shows at the outputs one clock after the cycle that requests it.

Top module: `stat_dword_ctl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, the doubleword holds bit 0 set and every other bit clear. In that cycle `blocked`, `priv_trap` and `instr_go` are low.
- R2: A cycle with `alu_valid` high and `load_valid` low writes bits 1..4 (`cond_code[3:0]` = bits 1,2,3,4) in the next cycle. The value is 1000 if `alu_exc` is high; otherwise it is 0100 for a signed `alu_result` above zero, 0010 below zero and 0001 equal to zero. All other bits keep their value.
- R3: With `alu_valid` and `load_valid` both low, the doubleword keeps its value, whatever the instruction inputs do.
- R4: A cycle with `load_valid` high makes the doubleword equal to `load_word` in the next cycle, with bit 31 and bits 33 to 46 forced to zero.
- R5: A load applies bits 48..49 of `load_word` to `blocked` in the same cycle. 00 clears it, 01 sets it, and 10 or 11 leave it unchanged.
- R6: When a load and a condition-code update arrive in the same cycle, bits 1..4 take the loaded value.
- R7: An instruction with `instr_valid` and `instr_priv` high, issued while bit 0 is clear, gives `priv_trap` high and `instr_go` low in the next cycle.
- R8: A valid instruction that is not privileged, or that is issued while bit 0 is set, gives `instr_go` high and `priv_trap` low in the next cycle. Both outputs are low in the cycle after a cycle with no valid instruction.
- R9: The field outputs follow the doubleword at these positions: `privileged` is bit 0, `ext_addr` bit 5, `base_mode` bit 6, `arith_trap_en` bit 7, `prog_ctr` bits 8..30 (bit 8 is its MSB), `right_half` bit 30, `mapped` bit 32, `keep_map` bit 47, and `proc_index` bits 50..63 (bit 50 is its MSB).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_valid | input | 1 | Condition-code update request |
| alu_result | input | RES_W | Signed arithmetic result |
| alu_exc | input | 1 | Arithmetic exception flag |
| load_valid | input | 1 | Load a new doubleword |
| load_word | input | 64 | New doubleword, bit 0 is the MSB |
| instr_valid | input | 1 | A decoded instruction is present |
| instr_priv | input | 1 | The decoded instruction is privileged |
| status_word | output | 64 | Current doubleword |
| privileged | output | 1 | Privileged state |
| cond_code | output | 4 | Condition codes, CC1 at bit 3 |
| ext_addr | output | 1 | Extended addressing option |
| base_mode | output | 1 | Base-register mode |
| arith_trap_en | output | 1 | Arithmetic exception trap enable |
| prog_ctr | output | 23 | Program counter field |
| right_half | output | 1 | Next instruction is a right halfword |
| mapped | output | 1 | Mapped environment |
| keep_map | output | 1 | Keep current map request |
| proc_index | output | 14 | Current process index |
| blocked | output | 1 | Interrupt blocking state |
| priv_trap | output | 1 | Privileged-violation trap request |
| instr_go | output | 1 | Decoded instruction may execute |

## Verification
The assertions assume that the control inputs are known, 0 or 1, in every cycle after reset. They also assume that the privilege check always sees the doubleword as it stood before a load in the same cycle. The bench drives every input at the falling edge and holds each request for exactly one cycle. It keeps a load apart from a privileged instruction, except in a case where the expected result follows the old privilege bit. It samples the outputs one falling edge later, so each check sees the single registered response to its own request.

// File: rtl/stat_dword_pkg.sv
package stat_dword_pkg;
  localparam int SW_W   = 64;
  localparam int PC_LO  = 8;
  localparam int PC_HI  = 30;
  localparam int PC_W   = PC_HI - PC_LO + 1;
  localparam int PIX_LO = 50;
  localparam int PIX_W  = SW_W - PIX_LO;
  localparam int CC_W   = 4;
  localparam int RSV_SOLO = 31;
  localparam int RSV_LO = 33;
  localparam int RSV_HI = 46;

  typedef enum logic [1:0] {
    BLK_OPEN   = 2'b00,
    BLK_SHUT   = 2'b01,
    BLK_HOLD_A = 2'b10,
    BLK_HOLD_B = 2'b11
  } blk_cmd_e;

  function automatic logic [0:SW_W-1] rsv_mask();
    logic [0:SW_W-1] m;
    m = '0;
    m[RSV_SOLO] = 1'b1;
    for (int i = RSV_LO; i <= RSV_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [0:SW_W-1] reset_word();
    logic [0:SW_W-1] w;
    w = '0;
    w[0] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/cc_eval.sv
module cc_eval #(
  parameter int RES_W = 32
) (
  input  logic [RES_W-1:0]     result,
  input  logic                 exc,
  output logic [0:stat_dword_pkg::CC_W-1] cc
);
  logic is_zero;
  logic is_neg;

  assign is_zero = (result == '0);
  assign is_neg  = result[RES_W-1];

  always_comb begin
    if (exc)          cc = 4'b1000;
    else if (is_zero) cc = 4'b0001;
    else if (is_neg)  cc = 4'b0010;
    else              cc = 4'b0100;
  end
endmodule

// File: rtl/blk_state.sv
module blk_state (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_valid,
  input  logic [1:0] cmd,
  output logic       blocked
);
  import stat_dword_pkg::*;

  blk_cmd_e cmd_e;
  assign cmd_e = blk_cmd_e'(cmd);

  always_ff @(posedge clk) begin
    if (rst) begin
      blocked <= 1'b0;
    end else if (load_valid) begin
      case (cmd_e)
        BLK_OPEN: blocked <= 1'b0;
        BLK_SHUT: blocked <= 1'b1;
        default:  blocked <= blocked;
      endcase
    end
  end

  assert_hold_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (load_valid && cmd[1]) |=> $stable(blocked));
  assert_shut_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (load_valid && cmd == 2'b01) |=> blocked);
  assert_open_cmd_R5: assert property (@(posedge clk) disable iff (rst)
    (load_valid && cmd == 2'b00) |=> !blocked);
  assert_no_load_R5: assert property (@(posedge clk) disable iff (rst)
    !load_valid |=> $stable(blocked));
endmodule

// File: rtl/priv_guard.sv
module priv_guard (
  input  logic clk,
  input  logic rst,
  input  logic instr_valid,
  input  logic instr_priv,
  input  logic priv_bit,
  output logic priv_trap,
  output logic instr_go
);
  logic violate;
  assign violate = instr_valid & instr_priv & ~priv_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      priv_trap <= 1'b0;
      instr_go  <= 1'b0;
    end else begin
      priv_trap <= violate;
      instr_go  <= instr_valid & ~violate;
    end
  end

  assert_trap_blocks_exec_R7: assert property (@(posedge clk) disable iff (rst)
    priv_trap |-> !instr_go);
  assert_open_instr_no_trap_R8: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !instr_priv) |=> (instr_go && !priv_trap));
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !instr_valid |=> (!instr_go && !priv_trap));
endmodule

// File: rtl/stat_dword_ctl.sv
module stat_dword_ctl #(
  parameter int RES_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alu_valid,
  input  logic [RES_W-1:0]      alu_result,
  input  logic                  alu_exc,
  input  logic                  load_valid,
  input  logic [0:63]           load_word,
  input  logic                  instr_valid,
  input  logic                  instr_priv,
  output logic [0:63]           status_word,
  output logic                  privileged,
  output logic [3:0]            cond_code,
  output logic                  ext_addr,
  output logic                  base_mode,
  output logic                  arith_trap_en,
  output logic [22:0]           prog_ctr,
  output logic                  right_half,
  output logic                  mapped,
  output logic                  keep_map,
  output logic [13:0]           proc_index,
  output logic                  blocked,
  output logic                  priv_trap,
  output logic                  instr_go
);
  import stat_dword_pkg::*;

  localparam logic [0:SW_W-1] RSV_MASK = rsv_mask();
  localparam logic [0:SW_W-1] RST_WORD = reset_word();

  logic [0:SW_W-1] word_q;
  logic [0:CC_W-1] cc_next;

  cc_eval #(.RES_W(RES_W)) u_cc (
    .result (alu_result),
    .exc    (alu_exc),
    .cc     (cc_next)
  );

  blk_state u_blk (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .cmd        (load_word[48:49]),
    .blocked    (blocked)
  );

  priv_guard u_guard (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_priv  (instr_priv),
    .priv_bit    (word_q[0]),
    .priv_trap   (priv_trap),
    .instr_go    (instr_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= RST_WORD;
    end else if (load_valid) begin
      word_q <= load_word & ~RSV_MASK;
    end else if (alu_valid) begin
      word_q[1:CC_W] <= cc_next;
    end
  end

  assign status_word   = word_q;
  assign privileged    = word_q[0];
  assign cond_code     = word_q[1:CC_W];
  assign ext_addr      = word_q[5];
  assign base_mode     = word_q[6];
  assign arith_trap_en = word_q[7];
  assign prog_ctr      = word_q[PC_LO:PC_HI];
  assign right_half    = word_q[PC_HI];
  assign mapped        = word_q[32];
  assign keep_map      = word_q[47];
  assign proc_index    = word_q[PIX_LO:SW_W-1];

  assert_reset_state_R1: assert property (@(posedge clk)
    $past(rst) |-> (word_q == RST_WORD && !blocked));
  assert_cc_single_R2: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && !load_valid) |=> ($countones(word_q[1:CC_W]) == 1));
  assert_cc_exc_R2: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && !load_valid && alu_exc) |=> word_q[1]);
  assert_cc_other_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (alu_valid && !load_valid) |=> ($stable(word_q[0]) && $stable(word_q[CC_W+1:SW_W-1])));
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!alu_valid && !load_valid) |=> $stable(word_q));
  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (!word_q[RSV_SOLO] && word_q[RSV_LO:RSV_HI] == '0));
  assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
    load_valid |=> (word_q[1:CC_W] == $past(load_word[1:CC_W])));
endmodule

// File: tb/test_stat_dword_ctl.sv
module test_stat_dword_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        alu_valid = 1'b0;
  logic [31:0] alu_result = '0;
  logic        alu_exc = 1'b0;
  logic        load_valid = 1'b0;
  logic [0:63] load_word = '0;
  logic        instr_valid = 1'b0;
  logic        instr_priv = 1'b0;
  logic [0:63] status_word;
  logic        privileged, ext_addr, base_mode, arith_trap_en, right_half;
  logic        mapped, keep_map, blocked, priv_trap, instr_go;
  logic [3:0]  cond_code;
  logic [22:0] prog_ctr;
  logic [13:0] proc_index;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [0:63] exp_w;
  logic        exp_blk;

  always #2 clk = ~clk;

  stat_dword_ctl #(.RES_W(32)) i_stat_dword_ctl (
    .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_result(alu_result),
    .alu_exc(alu_exc), .load_valid(load_valid), .load_word(load_word),
    .instr_valid(instr_valid), .instr_priv(instr_priv),
    .status_word(status_word), .privileged(privileged), .cond_code(cond_code),
    .ext_addr(ext_addr), .base_mode(base_mode), .arith_trap_en(arith_trap_en),
    .prog_ctr(prog_ctr), .right_half(right_half), .mapped(mapped),
    .keep_map(keep_map), .proc_index(proc_index), .blocked(blocked),
    .priv_trap(priv_trap), .instr_go(instr_go)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [0:63] masked(input logic [0:63] w);
    logic [0:63] r;
    r = w;
    r[31] = 1'b0;
    for (int i = 33; i <= 46; i++) r[i] = 1'b0;
    return r;
  endfunction

  task automatic clear_inputs();
    alu_valid = 1'b0; alu_exc = 1'b0; alu_result = '0;
    load_valid = 1'b0; load_word = '0;
    instr_valid = 1'b0; instr_priv = 1'b0;
  endtask

  task automatic do_load(input logic [0:63] w);
    load_valid = 1'b1; load_word = w;
    @(negedge clk);
    clear_inputs();
    exp_w = masked(w);
    if (w[48:49] == 2'b00) exp_blk = 1'b0;
    else if (w[48:49] == 2'b01) exp_blk = 1'b1;
  endtask

  task automatic do_alu(input logic [31:0] res, input logic exc, input logic [3:0] cc);
    alu_valid = 1'b1; alu_result = res; alu_exc = exc;
    @(negedge clk);
    clear_inputs();
    exp_w[1:4] = cc;
    check("R2 condition code", status_word, exp_w);
  endtask

  task automatic t_reset();
    check("R1 reset word", status_word, {1'b1, 63'b0});
    check("R1 reset blocked/trap/go", {61'b0, blocked, priv_trap, instr_go}, 64'd0);
    exp_w = {1'b1, 63'b0};
    exp_blk = 1'b0;
  endtask

  task automatic t_cc();
    do_alu(32'd5, 1'b0, 4'b0100);
    do_alu(32'hFFFF_FFFD, 1'b0, 4'b0010);
    do_alu(32'd0, 1'b0, 4'b0001);
    do_alu(32'h8000_0000, 1'b1, 4'b1000);
    do_alu(32'h7FFF_FFFF, 1'b0, 4'b0100);
  endtask

  task automatic t_hold();
    instr_valid = 1'b1; instr_priv = 1'b1;
    @(negedge clk);
    clear_inputs();
    @(negedge clk);
    check("R3 idle hold", status_word, exp_w);
  endtask

  task automatic t_load_fields();
    do_load({64{1'b1}} ^ {48'b0, 2'b01, 14'b0});
    check("R4 load masks reserved", status_word, exp_w);
    do_load(64'hA5C3_5A3C_F0F0_0F0F);
    check("R4 load pattern", status_word, exp_w);
    check("R9 mode bits",
      {57'b0, privileged, ext_addr, base_mode, arith_trap_en, right_half, mapped, keep_map},
      {57'b0, exp_w[0], exp_w[5], exp_w[6], exp_w[7], exp_w[30], exp_w[32], exp_w[47]});
    check("R9 cond_code", {60'b0, cond_code}, {60'b0, exp_w[1:4]});
    check("R9 prog_ctr", {41'b0, prog_ctr}, {41'b0, exp_w[8:30]});
    check("R9 proc_index", {50'b0, proc_index}, {50'b0, exp_w[50:63]});
  endtask

  task automatic t_block();
    logic [0:63] w;
    w = 64'h8000_0000_0000_0000;
    w[48:49] = 2'b01; do_load(w);
    check("R5 cmd 01 blocks", {63'b0, blocked}, {63'b0, exp_blk});
    w[48:49] = 2'b10; do_load(w);
    check("R5 cmd 10 keeps", {63'b0, blocked}, 64'd1);
    w[48:49] = 2'b00; do_load(w);
    check("R5 cmd 00 unblocks", {63'b0, blocked}, 64'd0);
    w[48:49] = 2'b11; do_load(w);
    check("R5 cmd 11 keeps", {63'b0, blocked}, 64'd0);
  endtask

  task automatic t_collide();
    logic [0:63] w;
    w = 64'h8000_0000_0000_0000;
    w[1:4] = 4'b0110;
    alu_valid = 1'b1; alu_result = 32'd9;
    do_load(w);
    check("R6 load wins", status_word, exp_w);
  endtask

  task automatic t_priv();
    do_load(64'h0000_1234_0000_0000);
    instr_valid = 1'b1; instr_priv = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R7 unprivileged priv instr", {62'b0, priv_trap, instr_go}, 64'b10);
    instr_valid = 1'b1; instr_priv = 1'b0;
    @(negedge clk);
    clear_inputs();
    check("R8 plain instr unprivileged", {62'b0, priv_trap, instr_go}, 64'b01);
    @(negedge clk);
    check("R8 no instr quiet", {62'b0, priv_trap, instr_go}, 64'b00);
    instr_valid = 1'b1; instr_priv = 1'b1;
    load_valid = 1'b1; load_word = 64'h8000_0000_0000_0000;
    @(negedge clk);
    clear_inputs();
    exp_w = 64'h8000_0000_0000_0000;
    check("R7 check uses old privilege", {62'b0, priv_trap, instr_go}, 64'b10);
    instr_valid = 1'b1; instr_priv = 1'b1;
    @(negedge clk);
    clear_inputs();
    check("R8 privileged instr allowed", {62'b0, priv_trap, instr_go}, 64'b01);
    check("R3 instr leaves word", status_word, exp_w);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cc();
    t_hold();
    t_load_fields();
    t_block();
    t_collide();
    t_priv();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule